// File: doc/BRIEF.md
# Watermark Offset Register Loader

This block fills the two threshold offsets that a FIFO's flag logic compares against: the almost-empty offset X and the almost-full offset Y. Two mode pins are captured while reset is held and pick how the offsets are filled. There are two fixed values, a parallel load from the write data bus, and a bit-serial load that reuses the two mode pins as an enable and a data line.

Until both offsets hold values, the ready output stays low and write requests never reach the storage. In parallel mode those write requests are taken as offset loads instead. When ready rises, the offsets are frozen and every later write request passes through to the storage as a FIFO write. Asserting reset again clears the ready output and captures the mode pins again.

Top module: `wmark_offset_loader`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `x_off`, `y_off` and `fifo_wr` are all 0.
- R2: The mode code `{mode_b, mode_a}` is captured on every clock edge that has `rst_n` low. The value captured at the last such edge selects the method: 2'b00 serial, 2'b01 fixed value PRESET_A (8), 2'b10 fixed value PRESET_B (16), 2'b11 parallel.
- R3: With code 2'b01, the first clock edge after reset release loads X and Y with 8 and sets `in_ready`.
- R4: With code 2'b10, the first clock edge after reset release loads X and Y with 16 and sets `in_ready`.
- R5: With code 2'b11, the first edge with `wr_en` high loads X from `wr_data`, and the second such edge loads Y and sets `in_ready` on that same edge. Neither of these writes raises `fifo_wr`.
- R6: With code 2'b00, every edge with `mode_b` high shifts in `mode_a`. There are 2*OW bits in total, OW being $clog2(DEPTH) (9 by default). The X bits come first and then the Y bits, each most significant bit first. Idle cycles may fall between bits. X and Y load on the edge of the last bit, and `in_ready` rises on the following edge.
- R7: A loaded value of 0 becomes 1, and a value above DEPTH-4 (508) becomes DEPTH-4. Other values are kept as given.
- R8: `fifo_wr` equals `wr_en` while `in_ready` is high and is 0 otherwise. Write requests made before that point are ignored.
- R9: Once `in_ready` is high, it stays high until the next reset. X and Y then stay constant whatever `wr_en`, `wr_data`, `mode_a` and `mode_b` do.
- R10: A new reset clears `in_ready` and the offsets, and the next load follows the newly captured mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are captured while it is low |
| mode_a | input | 1 | Mode bit 0; serial data during a serial load |
| mode_b | input | 1 | Mode bit 1; serial enable during a serial load |
| wr_en | input | 1 | Write request from the producer |
| wr_data | input | OW | Offset field of the write data bus |
| in_ready | output | 1 | Low during loading; high once the offsets are valid |
| fifo_wr | output | 1 | Write strobe passed to the FIFO storage |
| x_off | output | OW | Almost-empty offset |
| y_off | output | OW | Almost-full offset |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They also assume that, in serial mode, `mode_b` is low at that last reset edge, because that is what encodes serial mode. The bench changes inputs only on falling edges. It always holds reset for two edges with the wanted mode code on the pins, and it clears `mode_b` as reset is released before it sends serial bits. Random offsets cover the full OW-bit range, so values that need clamping appear next to the directed zero and maximum cases.

// File: rtl/wmark_offset_loader.sv
module wmark_offset_loader #(
  parameter int DEPTH    = 512,
  parameter int PRESET_A = 8,
  parameter int PRESET_B = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_a,
  input  logic                       mode_b,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_data,
  output logic                       in_ready,
  output logic                       fifo_wr,
  output logic [$clog2(DEPTH)-1:0]   x_off,
  output logic [$clog2(DEPTH)-1:0]   y_off
);
  localparam int OW = $clog2(DEPTH);
  localparam int SW = 2 * OW;
  localparam int CW = $clog2(SW);
  localparam logic [1:0] M_SER = 2'b00, M_PA = 2'b01, M_PB = 2'b10, M_PAR = 2'b11;
  localparam logic [OW-1:0] MAXV = OW'(DEPTH - 4);

  logic [1:0]    mode_q;
  logic          rdy, pend, par_ph;
  logic [CW-1:0] cnt;
  logic [SW-2:0] sr;
  logic [OW-1:0] x_q, y_q;
  logic [SW-1:0] nxt;

  function automatic logic [OW-1:0] fit(input logic [OW-1:0] v);
    if (v == '0)  return OW'(1);
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  assign nxt      = {sr, mode_a};
  assign in_ready = rdy;
  assign fifo_wr  = wr_en & rdy;
  assign x_off    = x_q;
  assign y_off    = y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= {mode_b, mode_a};
      rdy    <= 1'b0;
      pend   <= 1'b0;
      par_ph <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (!rdy) begin
      case (mode_q)
        M_PA: begin
          x_q <= OW'(PRESET_A);
          y_q <= OW'(PRESET_A);
          rdy <= 1'b1;
        end
        M_PB: begin
          x_q <= OW'(PRESET_B);
          y_q <= OW'(PRESET_B);
          rdy <= 1'b1;
        end
        M_PAR: begin
          if (wr_en) begin
            if (!par_ph) begin
              x_q    <= fit(wr_data);
              par_ph <= 1'b1;
            end else begin
              y_q <= fit(wr_data);
              rdy <= 1'b1;
            end
          end
        end
        default: begin
          if (pend) begin
            rdy <= 1'b1;
          end else if (mode_b) begin
            sr <= nxt[SW-2:0];
            if (cnt == CW'(SW - 1)) begin
              x_q  <= fit(nxt[SW-1:OW]);
              y_q  <= fit(nxt[OW-1:0]);
              pend <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R9
  offsets_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ($stable(x_off) && $stable(y_off)));

  // R7
  offsets_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (x_off >= OW'(1) && x_off <= MAXV && y_off >= OW'(1) && y_off <= MAXV));

  // R5
  par_rise_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ready) && mode_q == M_PAR) |-> $past(wr_en));

  // R6
  ser_rise_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_ready) && mode_q == M_SER) |-> $past(pend));
endmodule

// File: tb/tb_wmark_offset_loader.sv
module tb_wmark_offset_loader;
  localparam int CLK_P = 10;
  localparam int DEPTH = 512;
  localparam int OW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, mode_a = 0, mode_b = 0, wr_en = 0;
  logic [OW-1:0] wr_data = '0;
  logic in_ready, fifo_wr;
  logic [OW-1:0] x_off, y_off;
  int checks = 0, fails = 0;

  wmark_offset_loader #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
    .wr_en(wr_en), .wr_data(wr_data), .in_ready(in_ready),
    .fifo_wr(fifo_wr), .x_off(x_off), .y_off(y_off));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [OW-1:0] fitv(input logic [OW-1:0] v);
    if (v == 0) return 1;
    if (v > DEPTH - 4) return OW'(DEPTH - 4);
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge clk);
    rst_n = 0; mode_b = code[1]; mode_a = code[0]; wr_en = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R1 ready", in_ready, 0);
    chk("R1 x", x_off, 0);
    chk("R10 y", y_off, 0);
    rst_n = 1; mode_b = 0; mode_a = 0;
  endtask

  task automatic check_frozen(input logic [OW-1:0] ex, input logic [OW-1:0] ey);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_en = 1'($urandom); wr_data = OW'($urandom);
      mode_a = 1'($urandom); mode_b = 1'($urandom);
      #1;
      chk("R8 fifo_wr", fifo_wr, wr_en);
      @(posedge clk); #1;
      chk("R9 ready", in_ready, 1);
      chk("R9 x", x_off, ex);
      chk("R9 y", y_off, ey);
    end
    @(negedge clk);
    wr_en = 0; mode_a = 0; mode_b = 0;
  endtask

  task automatic run_preset(input logic [1:0] code, input int val, input string req);
    do_reset(code);
    @(posedge clk); #1;
    chk({req, " ready"}, in_ready, 1);
    chk({req, " x"}, x_off, val);
    chk({req, " y"}, y_off, val);
    check_frozen(OW'(val), OW'(val));
  endtask

  task automatic run_par(input logic [OW-1:0] a, input logic [OW-1:0] b, input int idle);
    do_reset(2'b11);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk); wr_en = 0; wr_data = OW'($urandom);
    end
    @(negedge clk);
    wr_en = 1; wr_data = a; #1;
    chk("R5 fifo_wr first", fifo_wr, 0);
    @(posedge clk); #1;
    chk("R5 ready after first", in_ready, 0);
    @(negedge clk);
    wr_data = b; #1;
    chk("R8 fifo_wr second", fifo_wr, 0);
    @(posedge clk); #1;
    chk("R5 ready", in_ready, 1);
    chk("R7 R5 x", x_off, fitv(a));
    chk("R7 R5 y", y_off, fitv(b));
    check_frozen(fitv(a), fitv(b));
  endtask

  task automatic run_ser(input logic [OW-1:0] a, input logic [OW-1:0] b, input int maxgap);
    logic [2*OW-1:0] w;
    w = {a, b};
    do_reset(2'b00);
    for (int i = 2*OW-1; i >= 0; i--) begin
      int g;
      g = (maxgap == 0) ? 0 : int'($urandom % (maxgap + 1));
      for (int k = 0; k < g; k++) begin
        @(negedge clk);
        mode_b = 0; mode_a = 1'($urandom); wr_en = 1'($urandom);
        #1;
        chk("R8 fifo_wr during serial", fifo_wr, 0);
      end
      @(negedge clk);
      mode_b = 1; mode_a = w[i]; wr_en = 0;
      @(posedge clk);
    end
    @(negedge clk);
    mode_b = 0; mode_a = 0;
    chk("R6 ready one edge late", in_ready, 0);
    @(posedge clk); #1;
    chk("R6 ready", in_ready, 1);
    chk("R7 R6 x", x_off, fitv(a));
    chk("R7 R6 y", y_off, fitv(b));
    check_frozen(fitv(a), fitv(b));
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk("R1 fifo_wr", fifo_wr, 0);
    run_preset(2'b01, 8, "R3");
    run_preset(2'b10, 16, "R4");
    run_par(9'd0, 9'd511, 0);
    run_par(9'd508, 9'd509, 2);
    run_par(9'd1, 9'd42, 1);
    run_ser(9'd0, 9'd511, 0);
    run_ser(9'd300, 9'd5, 3);
    // R2 R10: switching methods across resets
    run_preset(2'b01, 8, "R10");
    for (int r = 0; r < 6; r++) begin
      logic [OW-1:0] a, b;
      a = OW'($urandom); b = OW'($urandom);
      if (r % 2 == 0) run_par(a, b, int'($urandom % 3));
      else            run_ser(a, b, 2);
    end
    run_preset(2'b10, 16, "R2");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule